// File: doc/BRIEF.md
# General-Purpose Up-Counting Timer

This block is a 32-bit up-counting timer with a small register bank on a plain synchronous register bus. Software presets the counter, sets a reload value and an optional match value, and starts counting through one control register. The counter can advance on every clock or through a power-of-two prescaler. When it passes the all-ones value it either reloads or stops, and it raises a flag in both cases.

Three status flags record overflow, compare match and input capture. Software clears them by writing a one to the flag's bit. Two mask registers select which flags drive the interrupt line and which drive the wake-up line. Any write to the trigger register forces the counter to the load value. An external input can latch the counter on a selected edge. A single output pin can toggle on overflow and match events.

Every bus request is accepted in the cycle it is presented; the bus has no ready signal and never applies back-pressure. A read returns its data one cycle later, flagged by `rsp_valid`.

Top module: `tmr_top`

## Requirements
- R1: After reset, every register reads zero and `irq_o`, `wake_o`, `pwm_o` and `rsp_valid` are low.
- R2: A write takes effect at the clock edge where `bus_valid` and `bus_write` are high. A read presented at an edge returns `rsp_valid` high with its data after that edge, and `rsp_valid` is low in every other cycle. The registers are: status 0x18, interrupt mask 0x1C, wake mask 0x20, control 0x24, counter 0x28, load 0x2C, trigger 0x30, match 0x38, capture 0x3C.
- R3: While control bit 0 (run) is set and the prescaler is off, the counter advances by one on every clock.
- R4: With control bit 5 set, the counter advances once every 2^(p+1) clocks, where p is control bits 4:2. The first advance comes 2^(p+1) clocks after run is set.
- R5: When the counter advances from all ones, status bit 1 is set. If control bit 1 (auto-reload) is set, the counter takes the load register value.
- R6: At that overflow with auto-reload clear, the counter becomes zero and control bit 0 clears by itself.
- R7: Any write to the trigger register, whatever its data, loads the counter from the load register. A write to the counter register presets it directly. Both take priority over a count step in the same cycle.
- R8: With control bit 6 set, status bit 0 is set when a count step gives the counter a value equal to the match register.
- R9: Control bits 9:8 select the capture edge of `cap_in` (00 off, 01 rising, 10 falling, 11 both). A selected edge copies the counter into the capture register and sets status bit 2. Edges that are not selected change neither.
- R10: Writing a one to a status bit clears it. When a set event and a clear fall on the same edge, the set wins.
- R11: `irq_o` is high while any status bit is set whose interrupt mask bit is set. `wake_o` does the same with the wake mask.
- R12: Once run is clear, the counter holds its value. It changes only through a bus write or a trigger.
- R13: `pwm_o` equals control bit 7 XOR an internal toggle state. The toggle state flips on overflow when control bit 10 is set and on a match event when control bit 11 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register request present |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| cap_in | input | 1 | Asynchronous capture input |
| irq_o | output | 1 | Masked interrupt |
| wake_o | output | 1 | Masked wake-up request |
| pwm_o | output | 1 | Toggle/level output |

## Verification
The assertions check the following on every cycle:
- a single step with the prescaler off;
- the hold while stopped;
- the overflow flag, the reload and the one-shot stop at the all-ones boundary;
- the trigger reload;
- the one-cycle read response.

Only the bench scenarios can show the rest:
- the prescaled cadence over many clocks;
- compare, capture edge selection and the write-one-to-clear flags;
- the interrupt and wake-up masking;
- the output pin toggling.

The bench compares counter reads against a step model run from random presets, prescale settings and wait lengths.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int ADDR_W = 8;
  localparam int PTV_W  = 3;
  localparam int ST_W   = 3;
  localparam int CTRL_W = 12;

  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_WEN   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_CNT   = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_LOAD  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_TRIG  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_MATCH = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_CAP   = 8'h3C;

  localparam int ST_MATCH = 0;
  localparam int ST_OVF   = 1;
  localparam int ST_CAP   = 2;

  typedef enum logic [1:0] {CAP_OFF = 2'b00, CAP_RISE = 2'b01,
                            CAP_FALL = 2'b10, CAP_BOTH = 2'b11} cap_mode_e;

  // Packed MSB first: bit 0 is run.
  typedef struct packed {
    logic             tog_match;  // 11
    logic             tog_ovf;    // 10
    cap_mode_e        cap_edge;   // 9:8
    logic             pwm_idle;   // 7
    logic             cmp_en;     // 6
    logic             pre_en;     // 5
    logic [PTV_W-1:0] ptv;        // 4:2
    logic             auto_rl;    // 1
    logic             run;        // 0
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic             restart,
  input  logic [PTV_W-1:0] ptv,
  output logic             tick
);
  localparam int PC_W = 1 << PTV_W;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] limit;

  // Divide period is 2^(ptv+1); limit = period - 1 (wraps correctly at max ptv).
  always_comb limit = (PC_W'(2) << ptv) - PC_W'(1);
  always_comb tick  = run && (!pre_en || (pc_q == limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc_q <= '0;
    else if (!run || !pre_en || restart || tick)
      pc_q <= '0;
    else
      pc_q <= pc_q + PC_W'(1);
  end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             auto_rl,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             trig,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_ev,
  output logic             match_ev,
  output logic             oneshot_end
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic             wrap;
  logic             override;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    wrap        = tick && (cnt == MAXV);
    override    = wr_en || trig;
    nxt         = wrap ? (auto_rl ? load_val : '0) : cnt + CNT_W'(1);
    ovf_ev      = wrap && !override;
    oneshot_end = ovf_ev && !auto_rl;
    match_ev    = tick && !override && cmp_en && (nxt == match_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_en) cnt <= wr_val;
    else if (trig)  cnt <= load_val;
    else if (tick)  cnt <= nxt;
  end
endmodule

// File: rtl/tmr_capture.sv
`timescale 1ns/1ps
module tmr_capture #(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin,
  input  tmr_pkg::cap_mode_e mode,
  input  logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   cap_val,
  output logic               cap_ev
);
  import tmr_pkg::*;

  logic [2:0] sync_q;
  logic       rise;
  logic       fall;

  always_comb begin
    rise = sync_q[1] && !sync_q[2];
    fall = !sync_q[1] && sync_q[2];
    unique case (mode)
      CAP_RISE: cap_ev = rise;
      CAP_FALL: cap_ev = fall;
      CAP_BOTH: cap_ev = rise || fall;
      default:  cap_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      cap_val <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pin};
      if (cap_ev) cap_val <= cnt;
    end
  end
endmodule

// File: rtl/tmr_top.sv
`timescale 1ns/1ps
module tmr_top #(
  parameter int CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic [tmr_pkg::ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]           bus_wdata,
  output logic                       rsp_valid,
  output logic [CNT_W-1:0]           rsp_data,
  input  logic                       cap_in,
  output logic                       irq_o,
  output logic                       wake_o,
  output logic                       pwm_o
);
  import tmr_pkg::*;

  ctrl_t            ctrl_q;
  logic [ST_W-1:0]  st_q, ien_q, wen_q, st_set, st_clr;
  logic [CNT_W-1:0] load_q, match_q, cnt_q, cap_q, rd_mux;
  logic             tog_q;
  logic             wr, rd;
  logic             wr_ctrl, wr_cnt, wr_trig, wr_stat;
  logic             tick, ovf_ev, match_ev, oneshot_end, cap_ev;

  always_comb begin
    wr      = bus_valid && bus_write;
    rd      = bus_valid && !bus_write;
    wr_ctrl = wr && (bus_addr == OFF_CTRL);
    wr_cnt  = wr && (bus_addr == OFF_CNT);
    wr_trig = wr && (bus_addr == OFF_TRIG);
    wr_stat = wr && (bus_addr == OFF_STAT);
  end

  tmr_prescaler #(.PTV_W(PTV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .pre_en(ctrl_q.pre_en),
    .restart(wr_cnt || wr_trig), .ptv(ctrl_q.ptv), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .auto_rl(ctrl_q.auto_rl),
    .cmp_en(ctrl_q.cmp_en), .load_val(load_q), .match_val(match_q),
    .wr_en(wr_cnt), .wr_val(bus_wdata), .trig(wr_trig), .cnt(cnt_q),
    .ovf_ev(ovf_ev), .match_ev(match_ev), .oneshot_end(oneshot_end)
  );

  tmr_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_in), .mode(ctrl_q.cap_edge),
    .cnt(cnt_q), .cap_val(cap_q), .cap_ev(cap_ev)
  );

  // Status set events, indexed by flag position.
  always_comb begin
    st_set           = '0;
    st_set[ST_MATCH] = match_ev;
    st_set[ST_OVF]   = ovf_ev;
    st_set[ST_CAP]   = cap_ev;
    st_clr           = wr_stat ? bus_wdata[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ien_q   <= '0;
      wen_q   <= '0;
      st_q    <= '0;
      load_q  <= '0;
      match_q <= '0;
      tog_q   <= 1'b0;
    end else begin
      if (wr_ctrl)          ctrl_q     <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      else if (oneshot_end) ctrl_q.run <= 1'b0;
      if (wr && bus_addr == OFF_IEN)   ien_q   <= bus_wdata[ST_W-1:0];
      if (wr && bus_addr == OFF_WEN)   wen_q   <= bus_wdata[ST_W-1:0];
      if (wr && bus_addr == OFF_LOAD)  load_q  <= bus_wdata;
      if (wr && bus_addr == OFF_MATCH) match_q <= bus_wdata;
      st_q <= (st_q & ~st_clr) | st_set;
      if ((ovf_ev && ctrl_q.tog_ovf) ^ (match_ev && ctrl_q.tog_match))
        tog_q <= ~tog_q;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFF_STAT:  rd_mux = CNT_W'(st_q);
      OFF_IEN:   rd_mux = CNT_W'(ien_q);
      OFF_WEN:   rd_mux = CNT_W'(wen_q);
      OFF_CTRL:  rd_mux = CNT_W'(ctrl_q);
      OFF_CNT:   rd_mux = cnt_q;
      OFF_LOAD:  rd_mux = load_q;
      OFF_MATCH: rd_mux = match_q;
      OFF_CAP:   rd_mux = cap_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= rd_mux;
    end
  end

  always_comb begin
    irq_o  = |(st_q & ien_q);
    wake_o = |(st_q & wen_q);
    pwm_o  = ctrl_q.pwm_idle ^ tog_q;
  end
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd,
  input logic             rsp_valid,
  input logic             wr_cnt,
  input logic             wr_trig,
  input logic             wr_ctrl,
  input logic             run,
  input logic             auto_rl,
  input logic             pre_en,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load,
  input logic             st_ovf
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  assert_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pre_en && !wr_cnt && !wr_trig && cnt != MAXV)
      |=> cnt == $past(cnt) + CNT_W'(1));
  assert_tick_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);
  assert_ovf_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == MAXV && !wr_cnt && !wr_trig) |=> st_ovf);
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == MAXV && auto_rl && !wr_cnt && !wr_trig)
      |=> cnt == $past(load));
  assert_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == MAXV && !auto_rl && !wr_cnt && !wr_trig && !wr_ctrl)
      |=> (!run && cnt == '0));
  assert_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_trig && !wr_cnt) |=> cnt == $past(load));
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt && !wr_trig) |=> $stable(cnt));
endmodule

bind tmr_top tmr_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd(rd), .rsp_valid(rsp_valid),
  .wr_cnt(wr_cnt), .wr_trig(wr_trig), .wr_ctrl(wr_ctrl),
  .run(ctrl_q.run), .auto_rl(ctrl_q.auto_rl), .pre_en(ctrl_q.pre_en),
  .tick(tick), .cnt(cnt_q), .load(load_q), .st_ovf(st_q[tmr_pkg::ST_OVF])
);

// File: tb/tmr_top_tb_top.sv
`timescale 1ns/1ps
module tmr_top_tb_top;
  localparam logic [7:0] A_STAT = 8'h18, A_IEN = 8'h1C, A_WEN = 8'h20,
                         A_CTRL = 8'h24, A_CNT = 8'h28, A_LOAD = 8'h2C,
                         A_TRIG = 8'h30, A_MATCH = 8'h38, A_CAP = 8'h3C;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid, irq_o, wake_o, pwm_o;
  logic [31:0] rsp_data;
  logic        cap_in = 1'b0;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .cap_in(cap_in), .irq_o(irq_o), .wake_o(wake_o),
    .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    d = rsp_data;
    bus_valid = 1'b0;
  endtask

  // Step model: k idle clocks after the start write, period p.
  function automatic logic [31:0] model(input logic [31:0] v0, input int k,
      input int p, input bit ar, input logic [31:0] ld);
    logic [31:0] c = v0;
    bit running = 1'b1;
    for (int i = 0; i < k / p; i++) begin
      if (running) begin
        if (c == 32'hFFFF_FFFF) begin
          c = ar ? ld : 32'd0;
          if (!ar) running = 1'b0;
        end else c = c + 32'd1;
      end
    end
    return c;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, a0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {29'd0, irq_o, wake_o, pwm_o}, 32'd0);
    chk("R1 rsp", {31'd0, rsp_valid}, 32'd0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'd0);
    rd(A_CNT, d);  chk("R1 counter", d, 32'd0);
    rd(A_STAT, d); chk("R1 status", d, 32'd0);

    // R3 one step per clock
    wr(A_CNT, 32'd100); wr(A_CTRL, 32'h1);
    repeat (7) @(negedge clk);
    rd(A_CNT, d); chk("R3 free count", d, 32'd107);

    // R12 stop holds
    wr(A_CTRL, 32'h0);
    rd(A_CNT, a0);
    repeat (6) @(negedge clk);
    rd(A_CNT, d); chk("R12 hold after stop", d, a0);

    // R4 prescaler p=2 -> period 8
    wr(A_CNT, 32'd0); wr(A_CTRL, 32'h29);
    repeat (20) @(negedge clk);
    rd(A_CNT, d); chk("R4 prescaled", d, 32'd2);
    wr(A_CTRL, 32'h0);

    // R7 trigger and preset
    wr(A_LOAD, 32'h1234); wr(A_TRIG, 32'hDEAD);
    rd(A_CNT, d); chk("R7 trigger reload", d, 32'h1234);
    wr(A_CNT, 32'h77);
    rd(A_CNT, d); chk("R7 preset", d, 32'h77);

    // R5 overflow with auto-reload
    wr(A_CNT, 32'hFFFF_FFFD); wr(A_LOAD, 32'h100); wr(A_STAT, 32'h7);
    wr(A_CTRL, 32'h3);
    repeat (5) @(negedge clk);
    rd(A_CNT, d); chk("R5 reload", d, 32'h102);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, d); chk("R5 ovf flag", d & 32'h2, 32'h2);

    // R6 one-shot, R13 toggle on overflow, R11 wake mask
    wr(A_STAT, 32'h7); wr(A_WEN, 32'h2); wr(A_IEN, 32'h0);
    wr(A_CNT, 32'hFFFF_FFFE); wr(A_CTRL, 32'h481);
    chk("R13 idle level", {31'd0, pwm_o}, 32'd1);
    repeat (6) @(negedge clk);
    rd(A_CTRL, d); chk("R6 run cleared", d, 32'h480);
    rd(A_CNT, d);  chk("R6 counter zero", d, 32'd0);
    chk("R13 toggled", {31'd0, pwm_o}, 32'd0);
    chk("R11 wake only", {30'd0, wake_o, irq_o}, 32'h2);

    // R8 compare, R10 write-one-to-clear, R11 irq
    wr(A_WEN, 32'h0); wr(A_STAT, 32'h7); wr(A_IEN, 32'h1);
    wr(A_MATCH, 32'd14); wr(A_CNT, 32'd10); wr(A_CTRL, 32'h41);
    repeat (8) @(negedge clk);
    wr(A_CTRL, 32'h0);
    chk("R11 irq on match", {31'd0, irq_o}, 32'd1);
    rd(A_STAT, d); chk("R8 match flag", d, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R10 cleared", d, 32'h0);
    chk("R11 irq drops", {31'd0, irq_o}, 32'd0);

    // R9 capture edges
    wr(A_IEN, 32'h0); wr(A_CTRL, 32'h100); wr(A_CNT, 32'h55);
    cap_in = 1'b1; repeat (5) @(negedge clk);
    rd(A_CAP, d);  chk("R9 rise capture", d, 32'h55);
    rd(A_STAT, d); chk("R9 cap flag", d, 32'h4);
    wr(A_STAT, 32'h7); wr(A_CNT, 32'h66);
    cap_in = 1'b0; repeat (5) @(negedge clk);
    rd(A_STAT, d); chk("R9 fall ignored in rise mode", d, 32'h0);
    rd(A_CAP, d);  chk("R9 capture kept", d, 32'h55);
    wr(A_CTRL, 32'h200);
    cap_in = 1'b1; repeat (5) @(negedge clk);
    rd(A_STAT, d); chk("R9 rise ignored in fall mode", d, 32'h0);
    cap_in = 1'b0; repeat (5) @(negedge clk);
    rd(A_CAP, d);  chk("R9 fall capture", d, 32'h66);

    // R3 R4 R5 random presets, prescales and waits
    for (int i = 0; i < 40; i++) begin
      logic [31:0] v0, ld;
      int ptv, k, p;
      bit pe;
      v0  = (i % 4 == 0) ? (32'hFFFF_FFF0 | ($urandom % 16)) : $urandom;
      ld  = $urandom % 256;
      ptv = $urandom % 4;
      pe  = 1'($urandom % 2);
      k   = $urandom % 40;
      p   = pe ? (2 << ptv) : 1;
      wr(A_CTRL, 32'h0); wr(A_LOAD, ld); wr(A_CNT, v0);
      wr(A_CTRL, 32'h3 | (32'(pe) << 5) | (32'(ptv) << 2));
      repeat (k) @(negedge clk);
      rd(A_CNT, d);
      chk(pe ? "R4 random prescaled" : "R3 random count", d, model(v0, k, p, 1'b1, ld));
    end
    wr(A_CTRL, 32'h0);
    finish_run();
  end
endmodule